// File: doc/BRIEF.md
# Peripheral Sub-Interrupt Grouping Unit

This block collects the fine-grained interrupt requests of three serial ports and one analog converter and presents them to a main interrupt controller as four level-sensitive parent requests. Each serial port contributes three sub-requests: receive, transmit and error. The converter contributes two: touch and conversion-done. A rising edge on a sub-request latches a pending bit. A mask bit decides whether that pending bit may drive its parent.

Software reaches two registers over a simple single-cycle register bus. The pending register is cleared by writing ones. The mask register is written directly. A parent request stays high for as long as any unmasked pending bit in its group is set. The main controller therefore sees a level. Clearing a sub-pending bit is a separate step from acknowledging the parent in the main controller.

Top module: `subirq_group`

## Requirements
- R1: After reset the pending register reads 0, the mask register reads all ones in bits 10:0 (0x7FF), and every parent request is low.
- R2: A 0-to-1 transition on sub-request i sets pending bit i on the next clock edge, whatever the mask holds. A request held high sets the bit only once, so after the bit is cleared it stays clear while the request remains high.
- R3: A write to word address 0 clears every pending bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R4: If a rising edge on sub-request i and a clearing write to pending bit i fall in the same cycle, the bit ends up set.
- R5: A write to word address 1 loads the mask from write-data bits 10:0. A mask bit of 1 stops that pending bit from driving its parent, and the pending bit itself is kept.
- R6: Serial port n (n = 0..2) owns sub-bits 3n (receive), 3n+1 (transmit) and 3n+2 (error). Its parent uart_irq[n] is high exactly when at least one of those bits is pending and unmasked.
- R7: The converter owns sub-bit 9 (touch) and sub-bit 10 (conversion done). adc_irq is high exactly when one of those two bits is pending and unmasked.
- R8: bus_rdata shows the pending register at word address 0 and the mask at word address 1. Any other address reads 0. Bits 31:11 always read 0, and writes to those bits or to other addresses have no effect.
- R9: Parent requests are levels. A parent falls in the cycle after the last unmasked pending bit of its group is cleared or masked, and it stays high while any such bit remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_req | input | 11 | Sub-interrupt request lines, bit index as in R6/R7 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 pending, 1 mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| uart_irq | output | 3 | Level parent request per serial port |
| adc_irq | output | 1 | Level parent request of the converter |

## Verification
The bench uses the default parameters: three serial ports with three sub-bits each and two converter bits, 11 sources in all. This makes bit 10 the highest live bit, so the boundary between live bits and the zero-reading bits 31:11 is exercised. The unused address space is also reachable for reads and ignored writes. Directed steps cover a request held high across a clear, a set and a clear landing in the same cycle, and masking while a bit is pending. A long random run then mixes edges, clears and mask writes across all four groups.

// File: rtl/subirq_group.sv
module subirq_group #(
  parameter int NUM_UARTS = 3,
  parameter int UART_BITS = 3,
  parameter int ADC_BITS  = 2,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_UARTS*UART_BITS+ADC_BITS-1:0] periph_req,
  input  logic                                   bus_wr,
  input  logic [ADDR_W-1:0]                      bus_addr,
  input  logic [DATA_W-1:0]                      bus_wdata,
  output logic [DATA_W-1:0]                      bus_rdata,
  output logic [NUM_UARTS-1:0]                   uart_irq,
  output logic                                   adc_irq
);
  localparam int NSRC = NUM_UARTS*UART_BITS + ADC_BITS;
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(1);

  logic [NSRC-1:0] req_q, pend_q, mask_q;
  logic [NSRC-1:0] rise, live, wbits;
  logic            wr_pend, wr_mask;
  logic            unused_hi;

  assign rise      = periph_req & ~req_q;
  assign wbits     = bus_wdata[NSRC-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:NSRC];
  assign wr_pend   = bus_wr && (bus_addr == PEND_ADDR);
  assign wr_mask   = bus_wr && (bus_addr == MASK_ADDR);
  assign live      = pend_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      req_q  <= periph_req;
      pend_q <= (wr_pend ? (pend_q & ~wbits) : pend_q) | rise;
      if (wr_mask) mask_q <= wbits;
    end
  end

  for (genvar u = 0; u < NUM_UARTS; u++) begin : g_uart
    assign uart_irq[u] = |live[u*UART_BITS +: UART_BITS];
  end
  assign adc_irq = |live[NSRC-1 -: ADC_BITS];

  assign bus_rdata = (bus_addr == PEND_ADDR) ? {{(DATA_W-NSRC){1'b0}}, pend_q} :
                     (bus_addr == MASK_ADDR) ? {{(DATA_W-NSRC){1'b0}}, mask_q} :
                     '0;

  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(rise)) == $past(rise))); // R2

  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0)); // R2

  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && ((rise & wbits) == '0)) |=> ((pend_q & $past(wbits)) == '0)); // R3

  AST_MASK_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !wr_pend) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R5

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> (uart_irq == '0 && !adc_irq)); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NSRC] == '0); // R8

  AST_IDLE_ADC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[NSRC-1 -: ADC_BITS] == '0) |-> !adc_irq); // R7
endmodule

// File: tb/tb_subirq_group.sv
module tb_subirq_group;
  localparam int NSRC = 11;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [10:0] periph_req = '0;
  logic        bus_wr = 0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  uart_irq;
  logic        adc_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  subirq_group dut (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .uart_irq(uart_irq), .adc_irq(adc_irq)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  bit m_pend[NSRC];
  bit m_mask[NSRC];
  bit m_prev[NSRC];

  always @(posedge clk) begin
    for (int i = 0; i < NSRC; i++) begin
      if (!rst_n) begin
        m_pend[i] = 0; m_mask[i] = 1; m_prev[i] = 0;
      end else begin
        bit edge_seen;
        edge_seen = periph_req[i] && !m_prev[i];
        if (bus_wr && bus_addr == 2'd0 && bus_wdata[i]) m_pend[i] = 0;
        if (edge_seen) m_pend[i] = 1;
        if (bus_wr && bus_addr == 2'd1) m_mask[i] = bus_wdata[i];
        m_prev[i] = periph_req[i];
      end
    end
  end

  function automatic logic [31:0] exp_reg(input logic [1:0] a);
    logic [31:0] v = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (a == 2'd0) v[i] = m_pend[i];
      else if (a == 2'd1) v[i] = m_mask[i];
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0] eu;
      logic       ea;
      eu = '0;
      for (int n = 0; n < 3; n++)
        for (int k = 0; k < 3; k++)
          if (m_pend[3*n+k] && !m_mask[3*n+k]) eu[n] = 1'b1;
      ea = (m_pend[9] && !m_mask[9]) || (m_pend[10] && !m_mask[10]);
      check("R6 uart_irq vs model", {29'd0, uart_irq}, {29'd0, eu});
      check("R7 adc_irq vs model", {31'd0, adc_irq}, {31'd0, ea});
      check("R8 bus_rdata vs model", bus_rdata, exp_reg(bus_addr));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic peek(input string tag, input logic [1:0] a, input logic [31:0] exp);
    bus_addr = a; #2;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    peek("R1 pending after reset", 2'd0, 32'h0);
    peek("R1 mask after reset", 2'd1, 32'h7FF);
    check("R1 parents low after reset", {28'd0, adc_irq, uart_irq}, 32'd0);

    // R2: pulse transmit of port 1 while masked
    periph_req[4] = 1; tick(); periph_req[4] = 0; tick();
    peek("R2 pending set while masked", 2'd0, 32'h010);
    check("R5 masked parent low", {29'd0, uart_irq}, 32'd0);

    // R5/R8: unmask with junk in upper bits
    wr(2'd1, 32'hFFFF_F800);
    peek("R8 mask upper bits ignored", 2'd1, 32'h0);
    check("R6 port1 parent high", {29'd0, uart_irq}, 32'd2);

    // R2: held request does not re-set after clear
    periph_req[0] = 1; tick();
    check("R6 port0 parent high", {29'd0, uart_irq}, 32'd3);
    wr(2'd0, 32'h001); tick();
    peek("R2 held request not re-latched", 2'd0, 32'h010);
    check("R9 port0 parent fell", {29'd0, uart_irq}, 32'd2);

    // R4: edge and clear in same cycle
    periph_req[0] = 0;
    periph_req[9] = 1;
    wr(2'd0, 32'h200);
    periph_req[9] = 0;
    peek("R4 set wins over clear", 2'd0, 32'h210);
    check("R7 touch drives adc_irq", {31'd0, adc_irq}, 32'd1);

    // R3: clear only the written bits
    periph_req[10] = 1; periph_req[5] = 1; tick();
    periph_req[10] = 0; periph_req[5] = 0;
    wr(2'd0, 32'h210);
    peek("R3 only written bits cleared", 2'd0, 32'h420);
    check("R9 adc stays high on bit10", {31'd0, adc_irq}, 32'd1);

    // R5: mask a pending bit
    wr(2'd1, 32'h400);
    check("R5 masked adc low", {31'd0, adc_irq}, 32'd0);
    peek("R5 pending kept under mask", 2'd0, 32'h420);
    wr(2'd1, 32'h000);
    check("R7 adc high after unmask", {31'd0, adc_irq}, 32'd1);

    // R8: other addresses
    peek("R8 address 2 reads zero", 2'd2, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF);
    peek("R8 write to address 3 ignored (mask)", 2'd1, 32'h0);
    peek("R8 write to address 3 ignored (pend)", 2'd0, 32'h420);

    // R3/R9: clear all
    wr(2'd0, 32'hFFFF_FFFF);
    check("R9 all parents low after clear", {28'd0, adc_irq, uart_irq}, 32'd0);

    // random mix, compared against the model each cycle
    for (int c = 0; c < 3000; c++) begin
      int r;
      periph_req = 11'($urandom);
      r = $urandom_range(0, 9);
      if (r == 0) begin
        bus_wr = 1; bus_addr = 2'd0; bus_wdata = $urandom;
      end else if (r == 1) begin
        bus_wr = 1; bus_addr = 2'($urandom_range(1, 3)); bus_wdata = $urandom;
      end else begin
        bus_wr = 0; bus_addr = 2'($urandom_range(0, 3)); bus_wdata = '0;
      end
      tick();
    end
    bus_wr = 0;
    tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule